// File: doc/BRIEF.md
# SPI Select and Wait Handshake Control

This block sits beside an SPI shift engine and runs the two optional side pins of the serial link: an active-low slave-select line and an active-low ready/wait line. On a master it pulls the select line low for a character started through the select-asserting write port. The line goes high again when that character completes. A write through the plain port leaves the line high, so the master can reach every slave on the bus at once. The master also holds back clock pulses while the slave reports that it is not ready.

On a slave the incoming select line gates the engine. A deselected slave does not shift, floats its serial output and reports no received character. The slave drives the ready line in one of two styles. In open-drain style it only pulls the line low or floats it. In push-pull style it always drives the line, high or low. Each pin is given as a value plus an output-enable, so the floating cases can be seen directly. A pin takes part only while its function-enable input is set. The clock-mode input (`is_master`) picks the direction of each pin.

Top module: `spi_sel_wait_ctl`

## Requirements
- R1: On a master (`is_master`=1), a `wr_sel` pulse makes `sel_out` 0 after the next clock edge. This holds even when `xfer_done` pulses in the same cycle.
- R2: On a master, `sel_out` returns to 1 after the edge at which `xfer_done` pulses, unless `wr_sel` pulses in the same cycle.
- R3: `sel_out` never falls without a master `wr_sel`; a `wr_plain` write leaves it at 1.
- R4: `bit_grant` is 1 only for a master with `bit_req`=1. When `rdy_fn_en`=1, it also needs `rdy_in` low as seen through a two-flop synchronizer, which adds two cycles of delay. When `rdy_fn_en`=0, `bit_grant` follows `bit_req`.
- R5: A slave is deselected when `sel_fn_en`=1 and `sel_in`=1. While deselected, it has `shift_en`=0, `so_oe`=0 and `rx_evt`=0.
- R6: In open-drain style (`rdy_hiz_mode`=1), the slave drives `rdy_out`=0 with `rdy_oe`=1 after a write (`wr_plain` or `wr_sel`) made while it is selected. It floats the pin (`rdy_oe`=0) after a received character (`xfer_done`) or after becoming deselected.
- R7: In push-pull style (`rdy_hiz_mode`=0), the slave sets `rdy_out` to 1 after a character is received while it is selected. It sets `rdy_out` to 0 after a write while selected, after `rx_read`, or while deselected. In this style `rdy_oe` stays 1.
- R8: The pin directions are as follows. On a master, `sel_oe`=`sel_fn_en` and `rdy_oe`=0. On a slave, `sel_oe`=0, and `rdy_oe` can be 1 only when `rdy_fn_en`=1. With `sel_fn_en`=0, a slave is always selected.
- R9: Reset leaves `sel_out`=1, the ready state cleared (`rdy_out`=0, open-drain pin floating) and the synchronizer reading "not ready".

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| is_master | input | 1 | 1 = this side generates the serial clock |
| sel_fn_en | input | 1 | Select pin takes part in the link |
| rdy_fn_en | input | 1 | Ready/wait pin takes part in the link |
| rdy_hiz_mode | input | 1 | 1 = open-drain ready style, 0 = push-pull |
| wr_plain | input | 1 | Data written through the plain port |
| wr_sel | input | 1 | Data written through the select-asserting port |
| xfer_done | input | 1 | Engine finished a character |
| rx_read | input | 1 | Received character read by the host |
| bit_req | input | 1 | Engine at a bit boundary, asking for the next clock pulse |
| bit_grant | output | 1 | Next clock pulse may start |
| shift_en | output | 1 | Engine may shift |
| so_oe | output | 1 | Slave serial-output enable |
| rx_evt | output | 1 | Received-character event, gated by select |
| sel_in | input | 1 | Select pin input (slave) |
| sel_out | output | 1 | Select pin value (master) |
| sel_oe | output | 1 | Select pin output-enable |
| rdy_in | input | 1 | Ready pin input (master) |
| rdy_out | output | 1 | Ready pin value (slave) |
| rdy_oe | output | 1 | Ready pin output-enable |

## Verification
The assertions check the following on every cycle:
- the select line falls only on a select-port write and rises after completion;
- grants wait for the synchronized ready level;
- a deselected slave stays silent;
- the pin directions follow the clock mode.

The sequences of the ready pin can only be shown by the bench's scenarios: write, receive, read, and deselect, in each style. The same goes for the two-cycle synchronizer delay and the release of the stall, and for the precedence when a write and a completion meet in one cycle.

// File: rtl/spi_sel_wait_ctl.sv
module spi_sel_wait_ctl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic is_master,
  input  logic sel_fn_en,
  input  logic rdy_fn_en,
  input  logic rdy_hiz_mode,
  input  logic wr_plain,
  input  logic wr_sel,
  input  logic xfer_done,
  input  logic rx_read,
  input  logic bit_req,
  output logic bit_grant,
  output logic shift_en,
  output logic so_oe,
  output logic rx_evt,
  input  logic sel_in,
  output logic sel_out,
  output logic sel_oe,
  input  logic rdy_in,
  output logic rdy_out,
  output logic rdy_oe
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] rdy_sync;
  logic          sel_active;
  logic          hz_drive;
  logic          pp_high;

  wire selected = !sel_fn_en || !sel_in;
  wire slave    = !is_master;
  wire wr_any   = wr_plain || wr_sel;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                      sel_active <= 1'b0;
    else if (is_master && wr_sel)    sel_active <= 1'b1;
    else if (xfer_done || slave)     sel_active <= 1'b0;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) rdy_sync <= '1;
        else        rdy_sync <= rdy_in;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) rdy_sync <= '1;
        else        rdy_sync <= {rdy_sync[LAST-1:0], rdy_in};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                    hz_drive <= 1'b0;
    else if (is_master || !selected) hz_drive <= 1'b0;
    else if (wr_any)               hz_drive <= 1'b1;
    else if (xfer_done)            hz_drive <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                    pp_high <= 1'b0;
    else if (is_master || !selected) pp_high <= 1'b0;
    else if (wr_any)               pp_high <= 1'b0;
    else if (xfer_done)            pp_high <= 1'b1;
    else if (rx_read)              pp_high <= 1'b0;

  assign bit_grant = is_master && bit_req && (!rdy_fn_en || !rdy_sync[LAST]);
  assign shift_en  = is_master || selected;
  assign so_oe     = slave && selected;
  assign rx_evt    = xfer_done && shift_en;

  assign sel_out = !sel_active;
  assign sel_oe  = is_master && sel_fn_en;

  assign rdy_out = !rdy_hiz_mode && pp_high;
  assign rdy_oe  = slave && rdy_fn_en && (rdy_hiz_mode ? hz_drive : 1'b1);
endmodule

// File: rtl/spi_sel_wait_chk.sv
module spi_sel_wait_chk #(
  parameter int SYNC_STAGES = 2
) (
  input logic clk,
  input logic rst_n,
  input logic is_master,
  input logic sel_fn_en,
  input logic rdy_fn_en,
  input logic rdy_hiz_mode,
  input logic wr_plain,
  input logic wr_sel,
  input logic xfer_done,
  input logic bit_req,
  input logic bit_grant,
  input logic shift_en,
  input logic so_oe,
  input logic rx_evt,
  input logic sel_in,
  input logic sel_out,
  input logic sel_oe,
  input logic rdy_in,
  input logic rdy_out,
  input logic rdy_oe
);
  a_r1_sel_falls: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_sel && is_master) |-> !sel_out);

  a_r2_sel_rises: assert property (@(posedge clk) disable iff (!rst_n)
    $past(xfer_done && !(wr_sel && is_master)) |-> sel_out);

  a_r3_no_stray_select: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sel_out) && !$past(wr_sel && is_master)) |-> sel_out);

  a_r4_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    bit_grant |-> (bit_req && is_master));

  generate
    if (SYNC_STAGES == 2) begin : g_sync2
      a_r4_grant_synced_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_grant && rdy_fn_en) |-> !$past(rdy_in, 2));
    end
  endgenerate

  a_r5_deselected_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_master && sel_fn_en && sel_in) |-> (!shift_en && !so_oe && !rx_evt));

  a_r6_hiz_low_only: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_hiz_mode && rdy_oe) |-> !rdy_out);

  a_r6_hiz_float_after_rx: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(xfer_done && !wr_plain && !wr_sel) && !is_master && rdy_hiz_mode) |-> !rdy_oe);

  a_r7_pp_low_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sel_fn_en && sel_in) |-> !rdy_out);

  a_r8_master_dirs: assert property (@(posedge clk) disable iff (!rst_n)
    is_master |-> (!rdy_oe && (sel_oe == sel_fn_en)));

  a_r8_slave_dirs: assert property (@(posedge clk) disable iff (!rst_n)
    !is_master |-> (!sel_oe && (rdy_oe -> rdy_fn_en)));
endmodule

bind spi_sel_wait_ctl spi_sel_wait_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk(clk), .rst_n(rst_n), .is_master(is_master), .sel_fn_en(sel_fn_en),
  .rdy_fn_en(rdy_fn_en), .rdy_hiz_mode(rdy_hiz_mode), .wr_plain(wr_plain),
  .wr_sel(wr_sel), .xfer_done(xfer_done), .bit_req(bit_req),
  .bit_grant(bit_grant), .shift_en(shift_en), .so_oe(so_oe), .rx_evt(rx_evt),
  .sel_in(sel_in), .sel_out(sel_out), .sel_oe(sel_oe), .rdy_in(rdy_in),
  .rdy_out(rdy_out), .rdy_oe(rdy_oe)
);

// File: tb/spi_sel_wait_ctl_bench.sv
module spi_sel_wait_ctl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic is_master, sel_fn_en, rdy_fn_en, rdy_hiz_mode;
  logic wr_plain, wr_sel, xfer_done, rx_read, bit_req, sel_in, rdy_in;
  logic bit_grant, shift_en, so_oe, rx_evt, sel_out, sel_oe, rdy_out, rdy_oe;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  spi_sel_wait_ctl u_spi_sel_wait_ctl (
    .clk(clk), .rst_n(rst_n), .is_master(is_master), .sel_fn_en(sel_fn_en),
    .rdy_fn_en(rdy_fn_en), .rdy_hiz_mode(rdy_hiz_mode), .wr_plain(wr_plain),
    .wr_sel(wr_sel), .xfer_done(xfer_done), .rx_read(rx_read),
    .bit_req(bit_req), .bit_grant(bit_grant), .shift_en(shift_en),
    .so_oe(so_oe), .rx_evt(rx_evt), .sel_in(sel_in), .sel_out(sel_out),
    .sel_oe(sel_oe), .rdy_in(rdy_in), .rdy_out(rdy_out), .rdy_oe(rdy_oe)
  );

  // inputs: master sfe rfe hiz wp ws done rd sel_in rdy_in breq
  // expect: sel_out sel_oe rdy_out rdy_oe shift_en so_oe grant
  localparam int NV = 20;
  localparam logic [17:0] VEC [NV] = '{
    18'b1_1_0_0_0_0_0_0_1_1_1__1_1_0_0_1_0_1, // R8 master dirs, free grant
    18'b1_1_0_0_0_1_0_0_1_1_0__0_1_0_0_1_0_0, // R1 select write
    18'b1_1_0_0_0_0_0_0_1_1_0__0_1_0_0_1_0_0, // R1 held
    18'b1_1_0_0_0_0_1_0_1_1_0__1_1_0_0_1_0_0, // R2 done
    18'b1_1_0_0_1_0_0_0_1_1_0__1_1_0_0_1_0_0, // R3 plain write
    18'b1_0_0_0_0_0_1_0_1_1_0__1_0_0_0_1_0_0, // R8 select fn off
    18'b0_1_1_1_1_0_0_0_0_1_0__1_0_0_1_1_1_0, // R6 write -> drive low
    18'b0_1_1_1_0_0_1_0_0_1_0__1_0_0_0_1_1_0, // R6 receive -> float
    18'b0_1_1_1_1_0_0_0_0_1_0__1_0_0_1_1_1_0, // R6 write again
    18'b0_1_1_1_0_0_0_0_1_1_0__1_0_0_0_0_0_0, // R6 deselect -> float
    18'b0_1_1_1_1_0_0_0_1_1_0__1_0_0_0_0_0_0, // R6 write while deselected
    18'b0_1_1_0_0_0_1_0_0_1_0__1_0_1_1_1_1_0, // R7 receive -> high
    18'b0_1_1_0_0_0_0_0_0_1_0__1_0_1_1_1_1_0, // R7 hold
    18'b0_1_1_0_0_0_0_1_0_1_0__1_0_0_1_1_1_0, // R7 read -> low
    18'b0_1_1_0_0_0_1_0_0_1_0__1_0_1_1_1_1_0, // R7 receive
    18'b0_1_1_0_1_0_0_0_0_1_0__1_0_0_1_1_1_0, // R7 write -> low
    18'b0_1_1_0_0_0_1_0_0_1_0__1_0_1_1_1_1_0, // R7 receive
    18'b0_1_1_0_0_0_0_0_1_1_0__1_0_0_1_0_0_0, // R7 deselect -> low
    18'b0_0_1_0_0_0_1_0_1_1_0__1_0_1_1_1_1_0, // R8 select ignored
    18'b0_0_0_0_0_0_0_0_1_1_0__1_0_1_0_1_1_0  // R8 ready fn off
  };
  localparam int TAG [NV] = '{8,1,1,2,3,8,6,6,6,6,6,7,7,7,7,7,7,7,8,8};

  task automatic chk(input string req, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic drive(input logic [10:0] v);
    {is_master, sel_fn_en, rdy_fn_en, rdy_hiz_mode, wr_plain, wr_sel,
     xfer_done, rx_read, sel_in, rdy_in, bit_req} = v;
  endtask

  function automatic logic [6:0] outs();
    return {sel_out, sel_oe, rdy_out, rdy_oe, shift_en, so_oe, bit_grant};
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    // R9: reset state, slave push-pull configuration
    drive(11'b0_1_1_0_0_0_0_0_0_1_0);
    repeat (3) step();
    chk("R9", {5'b0, sel_out, rdy_out}, 7'b10);
    chk("R9", {6'b0, rdy_oe}, 7'b1);
    rst_n = 1'b1;
    step();
    chk("R9", {5'b0, rdy_out, rdy_oe}, 7'b01);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][17:7]);
      step();
      chk($sformatf("R%0d row %0d", TAG[i], i), outs(), VEC[i][6:0]);
    end

    // R4: wait through the synchronizer
    drive(11'b1_1_1_0_0_0_0_0_1_1_1);
    repeat (3) step();
    chk("R4 stalled", {6'b0, bit_grant}, 7'b0);
    rdy_in = 1'b0;
    step();
    chk("R4 one stage", {6'b0, bit_grant}, 7'b0);
    step();
    chk("R4 released", {6'b0, bit_grant}, 7'b1);
    rdy_in = 1'b1;
    step();
    chk("R4 still granted", {6'b0, bit_grant}, 7'b1);
    step();
    chk("R4 stalled again", {6'b0, bit_grant}, 7'b0);
    bit_req = 1'b0;
    rdy_in = 1'b0;
    repeat (2) step();
    chk("R4 no request", {6'b0, bit_grant}, 7'b0);

    // R1: select write and completion in one cycle
    wr_sel = 1'b1;
    xfer_done = 1'b1;
    step();
    wr_sel = 1'b0;
    xfer_done = 1'b0;
    chk("R1 priority", {6'b0, sel_out}, 7'b0);
    xfer_done = 1'b1;
    step();
    xfer_done = 1'b0;
    chk("R2 release", {6'b0, sel_out}, 7'b1);

    // R5: receive events gated by select
    drive(11'b0_1_1_0_0_0_1_0_1_1_0);
    #1;
    chk("R5 deselected rx_evt", {6'b0, rx_evt}, 7'b0);
    sel_in = 1'b0;
    #1;
    chk("R5 selected rx_evt", {6'b0, rx_evt}, 7'b1);
    step();
    xfer_done = 1'b0;

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog R9 actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule